// File: doc/BRIEF.md
# I2C Master Command and Data Queue Front-End

This block sits between a register port and the bit-level engine of an I2C master. Software writes command words into a transmit queue. Each word holds a data byte, a read/write selector and per-byte stop and restart markers. The engine takes these words in order and hands back the bytes it receives, which software then reads from a receive queue. The block reports how full each queue is. It compares those levels with programmable thresholds to produce a transmit-low flag and a receive-high flag. An engine abort discards the contents of both queues.

The controller is switched on and off through an enable register. A separate enable-status register shows the state actually in force. That state only follows the request while the engine reports no byte in flight, so software can poll it to learn when a change has taken hold. The engine is offered commands only while the enable status is on. A status register shows bus activity as reported by the engine, plus sticky flags for a dropped transmit write and for a read of an empty receive queue.

Top module: `i2cm_cmd_frontend`

## Requirements
- R1: A register write to address 0 with bit 8 clear queues a write command. The engine sees it on `cmd_word` in queue order, with the byte in bits 7:0, the stop marker in bit 9 and the restart marker in bit 10, exactly as written.
- R2: A register write to address 0 with bit 8 set queues a read command. Bit 8 is set in the word the engine receives, and the other bits are passed through unchanged.
- R3: A register read of address 0 removes the oldest received byte. That byte appears on `reg_rdata[7:0]` in the cycle after `reg_rd`, and bytes come out in the order they arrived.
- R4: Reading address 1 returns the transmit queue level. Reading address 2 returns the receive queue level. Both are zero-extended counts of stored entries.
- R5: `tx_low` is high when the transmit level is at or below the transmit threshold (address 3). It follows level and threshold changes one cycle after they take effect.
- R6: `rx_high` is high when the receive level is above the receive threshold (address 4). A threshold of 0 therefore raises it for a single stored byte. It has the same one-cycle lag as `tx_low`.
- R7: While `abort` is high, both queues are emptied at the clock edge. A queue write or engine byte in the same cycle is discarded.
- R8: A queue write to a full transmit queue is dropped and sets status bit 1 (address 7). The exception is when the engine pops in the same cycle: the write is then accepted and the flag stays clear.
- R9: A data read while the receive queue is empty returns 0 and sets status bit 2.
- R10: Status bit 0 shows `eng_active`. Reading the status register clears bits 1 and 2. A flag event in the same cycle as that read wins and leaves its bit set.
- R11: Enable-status (address 6, bit 0) takes the value of the enable request (address 5, bit 0) only in cycles with `eng_busy` low. `cmd_valid` is high only when enable-status is 1 and the transmit queue is not empty. Entries stay queued while the controller is disabled.
- R12: After reset both levels and thresholds are 0, enable and enable-status are 0, `cmd_valid` is 0, `tx_low` is 1 and `rx_high` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 11 | Register write data |
| reg_rdata | output | 11 | Registered read data, valid the cycle after `reg_rd` |
| cmd_valid | output | 1 | A command word is offered to the engine |
| cmd_word | output | 11 | Oldest command word: restart, stop, read, byte |
| cmd_pop | input | 1 | Engine takes the offered word |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| abort | input | 1 | Engine abort, empties both queues |
| eng_busy | input | 1 | A byte is in flight; holds the enable status |
| eng_active | input | 1 | Engine is active on the bus |
| tx_low | output | 1 | Transmit level at or below its threshold |
| rx_high | output | 1 | Receive level above its threshold |

## Verification
Two events can land in the same cycle: a register write to a full transmit queue and an engine pop, and an abort together with a queue write and an engine byte. The bench drives both strobes on the same falling edge. For the full-queue case, the level must stay at the full count, the overflow flag must stay clear and the new word must drain last. For the abort case, both levels must read back as zero and no command may be offered afterwards.

// File: rtl/i2cm_fe_pkg.sv
package i2cm_fe_pkg;
  localparam int CMD_W     = 11;
  localparam int BYTE_W    = 8;
  localparam int RD_BIT    = 8;
  localparam int STOP_BIT  = 9;
  localparam int RSTRT_BIT = 10;

  typedef enum logic [2:0] {
    RA_DATA   = 3'd0,
    RA_TXLVL  = 3'd1,
    RA_RXLVL  = 3'd2,
    RA_TXTHR  = 3'd3,
    RA_RXTHR  = 3'd4,
    RA_ENABLE = 3'd5,
    RA_ENSTAT = 3'd6,
    RA_STATUS = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic              restart;
    logic              stop;
    logic              rd;
    logic [BYTE_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/i2cm_fe_fifo.sv
module i2cm_fe_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == LW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_pop  = pop && !empty && !flush;
  assign do_push = push && (!full || do_pop) && !flush;
  assign dout    = mem[rp];
  assign level   = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      cnt <= cnt + LW'(do_push) - LW'(do_pop);
    end
  end
endmodule

// File: rtl/i2cm_fe_thresh.sv
module i2cm_fe_thresh #(
  parameter int LW    = 4,
  parameter bit ABOVE = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] thr,
  output logic          flag
);
  logic hit;

  generate
    if (ABOVE) begin : g_above
      assign hit = (level > thr);
    end else begin : g_at_or_below
      assign hit = (level <= thr);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) flag <= !ABOVE;
    else     flag <= hit;
  end
endmodule

// File: rtl/i2cm_fe_enable.sv
module i2cm_fe_enable (
  input  logic clk,
  input  logic rst,
  input  logic en_req,
  input  logic busy,
  output logic en_stat
);
  always_ff @(posedge clk) begin
    if (rst)        en_stat <= 1'b0;
    else if (!busy) en_stat <= en_req;
  end
endmodule

// File: rtl/i2cm_cmd_frontend.sv
module i2cm_cmd_frontend
  import i2cm_fe_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  localparam int TX_LW   = $clog2(TX_DEPTH + 1),
  localparam int RX_LW   = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [CMD_W-1:0]  reg_wdata,
  output logic [CMD_W-1:0]  reg_rdata,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_word,
  input  logic              cmd_pop,
  input  logic              rx_push,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              abort,
  input  logic              eng_busy,
  input  logic              eng_active,
  output logic              tx_low,
  output logic              rx_high
);
  logic [TX_LW-1:0]  tx_level, tx_thr;
  logic [RX_LW-1:0]  rx_level, rx_thr;
  logic              tx_full, tx_empty, rx_full_q, rx_empty;
  logic [BYTE_W-1:0] rx_head;
  logic              en_req, en_stat;
  logic              ovf, udf;
  logic              wr_data, rd_data, rd_status, tx_pop;
  logic              unused_rx_full;

  assign unused_rx_full = rx_full_q;
  assign wr_data   = reg_wr && (reg_addr == RA_DATA);
  assign rd_data   = reg_rd && (reg_addr == RA_DATA);
  assign rd_status = reg_rd && (reg_addr == RA_STATUS);
  assign cmd_valid = en_stat && !tx_empty;
  assign tx_pop    = cmd_pop && cmd_valid;

  i2cm_fe_fifo #(.W(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(abort),
    .push(wr_data), .din(reg_wdata),
    .pop(tx_pop), .dout(cmd_word),
    .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  i2cm_fe_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(abort),
    .push(rx_push), .din(rx_byte),
    .pop(rd_data), .dout(rx_head),
    .level(rx_level), .full(rx_full_q), .empty(rx_empty)
  );

  i2cm_fe_thresh #(.LW(TX_LW), .ABOVE(1'b0)) u_txthr (
    .clk(clk), .rst(rst), .level(tx_level), .thr(tx_thr), .flag(tx_low)
  );

  i2cm_fe_thresh #(.LW(RX_LW), .ABOVE(1'b1)) u_rxthr (
    .clk(clk), .rst(rst), .level(rx_level), .thr(rx_thr), .flag(rx_high)
  );

  i2cm_fe_enable u_en (
    .clk(clk), .rst(rst), .en_req(en_req), .busy(eng_busy), .en_stat(en_stat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_thr    <= '0;
      rx_thr    <= '0;
      en_req    <= 1'b0;
      ovf       <= 1'b0;
      udf       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          RA_TXTHR:  tx_thr <= reg_wdata[TX_LW-1:0];
          RA_RXTHR:  rx_thr <= reg_wdata[RX_LW-1:0];
          RA_ENABLE: en_req <= reg_wdata[0];
          default: ;
        endcase
      end
      if (rd_status) begin
        ovf <= 1'b0;
        udf <= 1'b0;
      end
      if (wr_data && tx_full && !tx_pop) ovf <= 1'b1;
      if (rd_data && rx_empty)           udf <= 1'b1;
      if (reg_rd) begin
        case (reg_addr)
          RA_DATA:   reg_rdata <= rx_empty ? '0 : CMD_W'(rx_head);
          RA_TXLVL:  reg_rdata <= CMD_W'(tx_level);
          RA_RXLVL:  reg_rdata <= CMD_W'(rx_level);
          RA_TXTHR:  reg_rdata <= CMD_W'(tx_thr);
          RA_RXTHR:  reg_rdata <= CMD_W'(rx_thr);
          RA_ENABLE: reg_rdata <= CMD_W'(en_req);
          RA_ENSTAT: reg_rdata <= CMD_W'(en_stat);
          default:   reg_rdata <= CMD_W'({rx_high, tx_low, udf, ovf, eng_active});
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cm_fe_checker.sv
module i2cm_fe_checker #(
  parameter int TX_DEPTH = 8,
  parameter int TX_LW    = 4,
  parameter int RX_LW    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             abort,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [2:0]       reg_addr,
  input logic             eng_busy,
  input logic             cmd_valid,
  input logic             tx_low,
  input logic             rx_high,
  input logic [TX_LW-1:0] tx_level,
  input logic [RX_LW-1:0] rx_level,
  input logic             en_stat,
  input logic             tx_full,
  input logic             rx_empty,
  input logic             tx_pop,
  input logic             ovf,
  input logic             udf
);
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    tx_level <= TX_LW'(TX_DEPTH)); // R4
  AST_ABORT_FLUSH: assert property (@(posedge clk) disable iff (rst)
    abort |=> (tx_level == '0) && (rx_level == '0)); // R7
  AST_NO_CMD_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !en_stat |-> !cmd_valid); // R11
  AST_EN_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
    eng_busy |=> $stable(en_stat)); // R11
  AST_TX_LOW_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (tx_level == '0) |=> tx_low); // R5
  AST_RX_HIGH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (rx_level == '0) |=> !rx_high); // R6
  AST_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 3'd0 && tx_full && !tx_pop) |=> ovf); // R8
  AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 3'd0 && rx_empty) |=> udf); // R9
endmodule

bind i2cm_cmd_frontend i2cm_fe_checker #(
  .TX_DEPTH(TX_DEPTH), .TX_LW(TX_LW), .RX_LW(RX_LW)
) u_chk (
  .clk(clk), .rst(rst), .abort(abort), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .eng_busy(eng_busy), .cmd_valid(cmd_valid),
  .tx_low(tx_low), .rx_high(rx_high), .tx_level(tx_level), .rx_level(rx_level),
  .en_stat(en_stat), .tx_full(tx_full), .rx_empty(rx_empty), .tx_pop(tx_pop),
  .ovf(ovf), .udf(udf)
);

// File: tb/test_i2cm_cmd_frontend.sv
module test_i2cm_cmd_frontend;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [10:0] reg_wdata = '0;
  logic [10:0] reg_rdata;
  logic        cmd_valid;
  logic [10:0] cmd_word;
  logic        cmd_pop = 1'b0, rx_push = 1'b0, abort = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        eng_busy = 1'b0, eng_active = 1'b0;
  logic        tx_low, rx_high;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2cm_cmd_frontend #(.TX_DEPTH(DEPTH), .RX_DEPTH(DEPTH)) i_i2cm_cmd_frontend (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
    .cmd_word(cmd_word), .cmd_pop(cmd_pop), .rx_push(rx_push), .rx_byte(rx_byte),
    .abort(abort), .eng_busy(eng_busy), .eng_active(eng_active),
    .tx_low(tx_low), .rx_high(rx_high)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [10:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; v = int'(reg_rdata);
  endtask

  task automatic pop(output int w, output int vld);
    @(negedge clk); w = int'(cmd_word); vld = int'(cmd_valid); cmd_pop = 1'b1;
    @(negedge clk); cmd_pop = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); rx_push = 1'b1; rx_byte = b;
    @(negedge clk); rx_push = 1'b0;
  endtask

  function automatic int exp_tx_low(input int lvl, input int thr);
    return (lvl <= thr) ? 1 : 0;
  endfunction

  function automatic int exp_rx_high(input int lvl, input int thr);
    return (lvl > thr) ? 1 : 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v, w, vld;
    int txq[$];
    int rxq[$];
    int unsigned seed;
    seed = $urandom(32'h51c3);

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 cmd_valid", int'(cmd_valid), 0);
    check("R12 tx_low", int'(tx_low), 1);
    check("R12 rx_high", int'(rx_high), 0);
    rd(3'd1, v); check("R12 tx level", v, 0);
    rd(3'd2, v); check("R12 rx level", v, 0);
    rd(3'd5, v); check("R12 enable", v, 0);
    rd(3'd6, v); check("R12 enable status", v, 0);

    eng_busy = 1'b1;
    wr(3'd5, 11'd1);
    repeat (3) @(negedge clk);
    rd(3'd6, v); check("R11 status held while busy", v, 0);
    eng_busy = 1'b0;
    @(negedge clk);
    rd(3'd6, v); check("R11 status follows enable", v, 1);

    wr(3'd0, 11'h0A5);
    wr(3'd0, 11'h300);
    wr(3'd0, 11'h4FF);
    rd(3'd1, v); check("R4 tx level three", v, 3);
    pop(w, vld); check("R1 write cmd", w, 'h0A5); check("R11 valid when enabled", vld, 1);
    pop(w, vld); check("R2 read cmd with stop", w, 'h300);
    pop(w, vld); check("R1 restart marker kept", w, 'h4FF);
    check("R11 no valid when empty", int'(cmd_valid), 0);

    wr(3'd3, 11'd2);
    wr(3'd0, 11'd1); wr(3'd0, 11'd2); wr(3'd0, 11'd3);
    @(negedge clk);
    check("R5 tx_low above thr", int'(tx_low), exp_tx_low(3, 2));
    pop(w, vld);
    @(negedge clk);
    check("R5 tx_low at thr", int'(tx_low), exp_tx_low(2, 2));
    pop(w, vld); pop(w, vld);

    push(8'h11);
    @(negedge clk);
    check("R6 rx_high thr0 one byte", int'(rx_high), exp_rx_high(1, 0));
    wr(3'd4, 11'd1);
    @(negedge clk);
    check("R6 rx_high at thr", int'(rx_high), exp_rx_high(1, 1));
    push(8'h22);
    @(negedge clk);
    check("R6 rx_high above thr", int'(rx_high), exp_rx_high(2, 1));
    rd(3'd2, v); check("R4 rx level", v, 2);
    rd(3'd0, v); check("R3 first byte", v, 'h11);
    rd(3'd0, v); check("R3 second byte", v, 'h22);
    wr(3'd4, 11'd0);

    rd(3'd0, v); check("R9 empty read zero", v, 0);
    rd(3'd7, v); check("R9 underflow bit", (v >> 2) & 1, 1);
    rd(3'd7, v); check("R10 status read clears", (v >> 1) & 3, 0);

    for (int i = 0; i < DEPTH; i++) wr(3'd0, 11'(16 + i));
    wr(3'd0, 11'h07E);
    rd(3'd1, v); check("R8 level stays full", v, DEPTH);
    rd(3'd7, v); check("R8 overflow bit", (v >> 1) & 1, 1);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 11'h055; cmd_pop = 1'b1;
    w = int'(cmd_word);
    @(negedge clk);
    reg_wr = 1'b0; cmd_pop = 1'b0;
    check("R8 pop during full write", w, 16);
    rd(3'd1, v); check("R8 full write with pop level", v, DEPTH);
    rd(3'd7, v); check("R8 no overflow with pop", (v >> 1) & 1, 0);
    for (int i = 1; i < DEPTH; i++) begin
      pop(w, vld); check("R1 drain order", w, 16 + i);
    end
    pop(w, vld); check("R8 accepted word last", w, 'h055);

    wr(3'd0, 11'h001); wr(3'd0, 11'h002);
    push(8'hA1); push(8'hA2);
    @(negedge clk);
    abort = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 11'h077;
    rx_push = 1'b1; rx_byte = 8'hEE;
    @(negedge clk);
    abort = 1'b0; reg_wr = 1'b0; rx_push = 1'b0;
    rd(3'd1, v); check("R7 tx flushed", v, 0);
    rd(3'd2, v); check("R7 rx flushed", v, 0);
    check("R7 nothing offered", int'(cmd_valid), 0);

    eng_active = 1'b1;
    rd(3'd7, v); check("R10 activity high", v & 1, 1);
    eng_active = 1'b0;
    rd(3'd7, v); check("R10 activity low", v & 1, 0);

    wr(3'd0, 11'h012);
    wr(3'd5, 11'd0);
    repeat (2) @(negedge clk);
    check("R11 disabled blocks valid", int'(cmd_valid), 0);
    rd(3'd1, v); check("R11 entry kept", v, 1);
    wr(3'd5, 11'd1);
    repeat (2) @(negedge clk);
    check("R11 re-enabled valid", int'(cmd_valid), 1);
    pop(w, vld); check("R1 kept entry", w, 'h012);

    wr(3'd3, 11'd3);
    wr(3'd4, 11'd2);
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom % 4);
      case (op)
        0: if (txq.size() < DEPTH) begin
             w = int'($urandom & 32'h7FF);
             wr(3'd0, 11'(w));
             txq.push_back(w);
           end
        1: if (txq.size() > 0) begin
             pop(w, vld);
             check("R1 R2 random cmd", w, txq.pop_front());
           end
        2: if (rxq.size() < DEPTH) begin
             v = int'($urandom & 32'hFF);
             push(8'(v));
             rxq.push_back(v);
           end
        default: if (rxq.size() > 0) begin
             rd(3'd0, v);
             check("R3 random byte", v, rxq.pop_front());
           end
      endcase
      @(negedge clk);
      check("R5 random tx_low", int'(tx_low), exp_tx_low(txq.size(), 3));
      check("R6 random rx_high", int'(rx_high), exp_rx_high(rxq.size(), 2));
      if (it % 16 == 0) begin
        rd(3'd1, v); check("R4 random tx level", v, txq.size());
        rd(3'd2, v); check("R4 random rx level", v, rxq.size());
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule